// File: doc/BRIEF.md
# Single-Channel DMA Transfer Controller

This block runs one programmed DMA transfer at a time toward a downstream packet consumer. Software, or a test harness, sets a memory address and a quadword count and then writes the control register with its start bit set. The controller then streams payload quadwords over a valid/ready beat interface. Once the last beat has gone out, it waits for a completion pulse from the consumer before it finishes.

Payload is not fetched from memory. A small local buffer is filled beforehand through a test push port. The address register is only reported in the trace stream.

Every lifecycle step produces one trace record with a fixed argument layout. There are four record types: configuration, start, one record per beat, and completion. These records let an integration bench prove that the channel took part in a transfer, not just that the end result appeared.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: After reset the controller is idle: `busy`, `beat_valid` and `trace_valid` are low.
- R2: A write with `reg_wr_sel`=0 (control), made while idle, with bit 0 (start) set, starts a transfer. On the next cycle a record of kind 1 (config) appears with: arg0 = channel id, arg1 = written control bits [3:0] (bit1 direction, bits 3:2 mode), arg2 = address register (sel 1), arg3 = count register (sel 2, quadwords), and flags = mode. `busy` rises in the same cycle.
- R3: The cycle after the config record, a record of kind 2 (start) appears with: arg0 = channel, arg1 = count, arg2 = planned beats, arg3 = path id.
- R4: From the cycle after the start record, `beat_valid` is high while beats remain. `beat_data` presents the buffered quadwords in push order. A beat moves only when valid and ready are both high, and data stays stable while the consumer stalls.
- R5: Each accepted beat yields, one cycle later, a record of kind 3 with: arg0 = channel, arg1 = beat index, arg2 = beat bits [31:0], arg3 = beats remaining after it.
- R6: After the last beat, `busy` stays high until `cons_done` is seen. One cycle after that, `busy` falls. In the same cycle a record of kind 4 appears with: arg0 = channel, arg1 = beats sent, arg2 = completion code, arg3 = path id. Code 0 means success.
- R7: A count of zero issues no beats. It reports planned beats 0 and then completion code 1, without waiting for `cons_done`.
- R8: A count above the number of loaded quadwords is clamped to that number and reports code 2. If nothing is loaded, no beats are issued.
- R9: A nonzero mode field (control bits 3:2) is unsupported: no beats, planned 0, code 3.
- R10: Register writes and buffer pushes made while a transfer is in progress are ignored.
- R11: The buffer keeps at most `BUF_DEPTH` quadwords, ignores pushes when full, and is emptied when a transfer completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | 0 control, 1 address, 2 count |
| reg_wr_data | input | 32 | Register write data |
| pl_push | input | 1 | Append one quadword to the payload buffer |
| pl_data | input | BEAT_W | Quadword being pushed |
| beat_valid | output | 1 | Beat on offer |
| beat_ready | input | 1 | Consumer takes the beat |
| beat_data | output | BEAT_W | Beat payload |
| cons_done | input | 1 | Consumer completion pulse |
| busy | output | 1 | Transfer in progress |
| trace_valid | output | 1 | Trace record present |
| trace_kind | output | 3 | 1 config, 2 start, 3 beat, 4 done |
| trace_arg0 | output | 32 | Record argument 0 |
| trace_arg1 | output | 32 | Record argument 1 |
| trace_arg2 | output | 32 | Record argument 2 |
| trace_arg3 | output | 32 | Record argument 3 |
| trace_flags | output | 8 | Record flags |

## Verification
The bench keeps the default parameters: channel 2, path 1, a four-quadword buffer and 128-bit beats. A depth of four makes the full-buffer case reachable with six pushes. It also brings the clamp to the loaded count within reach in a short run, as well as beat indices and remaining counts that span every buffer slot.

The consumer's ready line runs in three patterns: always ready, alternating, and held low across the window in which stale register writes and pushes are attempted. The completion pulse is held back after the last beat to show the channel keeps waiting for it.

// File: rtl/dma_xfer_pkg.sv
// Shared encodings for the single-channel DMA controller.
// Assumes one direct mode; field positions here are decoded by the FSM and bench.
package dma_xfer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_DONE   = 2'd3
    } chan_state_e;

    typedef enum logic [2:0] {
        TRK_NONE  = 3'd0,
        TRK_CFG   = 3'd1,
        TRK_START = 3'd2,
        TRK_BEAT  = 3'd3,
        TRK_DONE  = 3'd4
    } trace_kind_e;

    localparam int REG_W = 32;

    localparam logic [1:0] SEL_CTRL  = 2'd0;
    localparam logic [1:0] SEL_ADDR  = 2'd1;
    localparam logic [1:0] SEL_COUNT = 2'd2;

    localparam int CTL_START = 0;
    localparam logic [1:0] MODE_DIRECT = 2'd0;

    localparam logic [7:0] CC_OK      = 8'd0;
    localparam logic [7:0] CC_ZERO    = 8'd1;
    localparam logic [7:0] CC_CLAMP   = 8'd2;
    localparam logic [7:0] CC_BADMODE = 8'd3;

    typedef struct packed {
        logic        valid;
        trace_kind_e kind;
        logic [31:0] a0;
        logic [31:0] a1;
        logic [31:0] a2;
        logic [31:0] a3;
        logic [7:0]  flags;
    } trace_rec_t;

endpackage

// File: rtl/dma_chan_regs.sv
// Register shell: address, count and mode fields of the channel.
// Assumes writes are only taken while accept_en is high (controller idle).
module dma_chan_regs
    import dma_xfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              accept_en,
    output logic [ADDR_W-1:0] addr_q,
    output logic [CNT_W-1:0]  count_q,
    output logic [1:0]        mode_q,
    output logic [3:0]        start_ctrl,
    output logic              start_pulse
);

    logic take;
    assign take = wr_en && accept_en;

    // Start request is decoded straight from the accepted control write.
    always_comb begin
        start_ctrl  = wr_data[3:0];
        start_pulse = take && (wr_sel == SEL_CTRL) && wr_data[CTL_START];
    end

    // Latch the register selected by an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            count_q <= '0;
            mode_q  <= MODE_DIRECT;
        end else if (take) begin
            case (wr_sel)
                SEL_ADDR:  addr_q  <= wr_data[ADDR_W-1:0];
                SEL_COUNT: count_q <= wr_data[CNT_W-1:0];
                SEL_CTRL:  mode_q  <= wr_data[3:2];
                default:   ;
            endcase
        end
    end

    // R10: a write during a transfer leaves address and count untouched.
    p_locked_regs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !accept_en) |=> ($stable(addr_q) && $stable(count_q)));

endmodule

// File: rtl/dma_qw_buffer.sv
// Local quadword buffer filled by an append-only test port, read by index.
// Assumes reads only below the fill level; clear has priority over push.
module dma_qw_buffer #(
    parameter int DEPTH  = 4,
    parameter int BEAT_W = 128,
    localparam int FILL_W = $clog2(DEPTH + 1),
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [BEAT_W-1:0] push_data,
    input  logic              push_en,
    input  logic              clear,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [BEAT_W-1:0] rd_data,
    output logic [FILL_W-1:0] fill_q
);

    logic [BEAT_W-1:0] slot_q [DEPTH];
    logic              room;
    logic              take;

    assign room = (fill_q != FILL_W'(DEPTH));
    assign take = push && push_en && room && !clear;

    // Track how many quadwords are loaded.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) fill_q <= '0;
        else if (take)       fill_q <= fill_q + FILL_W'(1);
    end

    // One storage register per slot, written when it is the next free one.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)                            slot_q[g] <= '0;
            else if (take && fill_q == FILL_W'(g)) slot_q[g] <= push_data;
        end
    end

    assign rd_data = slot_q[rd_idx];

    // R11: a push into a full buffer is dropped.
    p_full_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !room && !clear) |=> (fill_q == FILL_W'(DEPTH)));

endmodule

// File: rtl/dma_chan_fsm.sv
// Transfer sequencer: IDLE -> ARMED -> ACTIVE -> DONE -> IDLE.
// Plans the beat count, streams beats, waits for the consumer's completion
// pulse and emits one registered trace record per lifecycle step.
// Assumes mode/address/count are frozen while not idle.
module dma_chan_fsm
    import dma_xfer_pkg::*;
#(
    parameter int CH_ID   = 2,
    parameter int PATH_ID = 1,
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 16,
    parameter int FILL_W  = 3,
    parameter int IDX_W   = 2,
    parameter int BEAT_W  = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_pulse,
    input  logic [3:0]        start_ctrl,
    input  logic [1:0]        mode_q,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [CNT_W-1:0]  count_q,
    input  logic [FILL_W-1:0] fill,
    input  logic [BEAT_W-1:0] rd_data,
    input  logic              beat_ready,
    input  logic              cons_done,
    output logic              beat_valid,
    output logic [BEAT_W-1:0] beat_data,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              accept_en,
    output logic              buf_clear,
    output chan_state_e       state_q,
    output trace_rec_t        trace_q
);

    logic [FILL_W-1:0] planned_q, sent_q;
    logic [7:0]        code_q;
    logic              bad_mode, zero_cnt, clamp;
    logic [FILL_W-1:0] planned_d, remain;
    logic [7:0]        code_d;
    logic              fire;

    // Plan beats and completion code from the frozen registers.
    always_comb begin
        bad_mode  = (mode_q != MODE_DIRECT);
        zero_cnt  = (count_q == '0);
        clamp     = (CNT_W'(fill) < count_q);
        planned_d = bad_mode ? '0 : (clamp ? fill : count_q[FILL_W-1:0]);
        if (bad_mode)      code_d = CC_BADMODE;
        else if (zero_cnt) code_d = CC_ZERO;
        else if (clamp)    code_d = CC_CLAMP;
        else               code_d = CC_OK;
    end

    // Beat offer and handshake.
    always_comb begin
        beat_valid = (state_q == ST_ACTIVE) && (sent_q != planned_q);
        fire       = beat_valid && beat_ready;
        rd_idx     = sent_q[IDX_W-1:0];
        beat_data  = rd_data;
        remain     = planned_q - sent_q - FILL_W'(1);
        accept_en  = (state_q == ST_IDLE);
        buf_clear  = (state_q == ST_DONE);
    end

    // Sequence the transfer and register one trace record per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            planned_q <= '0;
            sent_q    <= '0;
            code_q    <= CC_OK;
            trace_q   <= '0;
        end else begin
            trace_q <= '0;
            case (state_q)
                ST_IDLE: if (start_pulse) begin
                    state_q       <= ST_ARMED;
                    trace_q.valid <= 1'b1;
                    trace_q.kind  <= TRK_CFG;
                    trace_q.a0    <= 32'(CH_ID);
                    trace_q.a1    <= 32'(start_ctrl);
                    trace_q.a2    <= 32'(addr_q);
                    trace_q.a3    <= 32'(count_q);
                    trace_q.flags <= 8'(start_ctrl[3:2]);
                end
                ST_ARMED: begin
                    planned_q     <= planned_d;
                    sent_q        <= '0;
                    code_q        <= code_d;
                    state_q       <= (planned_d == '0) ? ST_DONE : ST_ACTIVE;
                    trace_q.valid <= 1'b1;
                    trace_q.kind  <= TRK_START;
                    trace_q.a0    <= 32'(CH_ID);
                    trace_q.a1    <= 32'(count_q);
                    trace_q.a2    <= 32'(planned_d);
                    trace_q.a3    <= 32'(PATH_ID);
                end
                ST_ACTIVE: begin
                    if (fire) begin
                        sent_q        <= sent_q + FILL_W'(1);
                        trace_q.valid <= 1'b1;
                        trace_q.kind  <= TRK_BEAT;
                        trace_q.a0    <= 32'(CH_ID);
                        trace_q.a1    <= 32'(sent_q);
                        trace_q.a2    <= rd_data[31:0];
                        trace_q.a3    <= 32'(remain);
                    end else if (sent_q == planned_q && cons_done) begin
                        state_q <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    state_q       <= ST_IDLE;
                    trace_q.valid <= 1'b1;
                    trace_q.kind  <= TRK_DONE;
                    trace_q.a0    <= 32'(CH_ID);
                    trace_q.a1    <= 32'(sent_q);
                    trace_q.a2    <= 32'(code_q);
                    trace_q.a3    <= 32'(PATH_ID);
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R4: a stalled beat keeps its offer and its data.
    p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_data)));

    // R5: every accepted beat is followed by a beat record.
    p_beat_trace_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_ready) |=> (trace_q.valid && trace_q.kind == TRK_BEAT));

    // R3: a config record is always followed by a start record.
    p_cfg_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (trace_q.valid && trace_q.kind == TRK_CFG) |=>
        (trace_q.valid && trace_q.kind == TRK_START));

    // R7: a zero count never offers a beat and heads straight to DONE.
    p_zero_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && count_q == '0) |=> (!beat_valid && state_q == ST_DONE));

endmodule

// File: rtl/dma_xfer_ctrl.sv
// Top of the single-channel DMA controller: register shell, payload buffer
// and transfer sequencer, with the trace record flattened onto ports.
// Assumes ADDR_W and CNT_W do not exceed the 32-bit register width.
module dma_xfer_ctrl
    import dma_xfer_pkg::*;
#(
    parameter int CH_ID     = 2,
    parameter int PATH_ID   = 1,
    parameter int BUF_DEPTH = 4,
    parameter int BEAT_W    = 128,
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_wr_sel,
    input  logic [31:0]       reg_wr_data,
    input  logic              pl_push,
    input  logic [BEAT_W-1:0] pl_data,
    output logic              beat_valid,
    input  logic              beat_ready,
    output logic [BEAT_W-1:0] beat_data,
    input  logic              cons_done,
    output logic              busy,
    output logic              trace_valid,
    output logic [2:0]        trace_kind,
    output logic [31:0]       trace_arg0,
    output logic [31:0]       trace_arg1,
    output logic [31:0]       trace_arg2,
    output logic [31:0]       trace_arg3,
    output logic [7:0]        trace_flags
);

    localparam int FILL_W = $clog2(BUF_DEPTH + 1);
    localparam int IDX_W  = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  count_q;
    logic [1:0]        mode_q;
    logic [3:0]        start_ctrl;
    logic              start_pulse, accept_en, buf_clear;
    logic [IDX_W-1:0]  rd_idx;
    logic [BEAT_W-1:0] rd_data;
    logic [FILL_W-1:0] fill;
    chan_state_e       state_q;
    trace_rec_t        trace_q;

    dma_chan_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_sel(reg_wr_sel),
        .wr_data(reg_wr_data), .accept_en(accept_en), .addr_q(addr_q),
        .count_q(count_q), .mode_q(mode_q), .start_ctrl(start_ctrl),
        .start_pulse(start_pulse)
    );

    dma_qw_buffer #(.DEPTH(BUF_DEPTH), .BEAT_W(BEAT_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .push(pl_push), .push_data(pl_data),
        .push_en(accept_en), .clear(buf_clear), .rd_idx(rd_idx),
        .rd_data(rd_data), .fill_q(fill)
    );

    dma_chan_fsm #(
        .CH_ID(CH_ID), .PATH_ID(PATH_ID), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
        .FILL_W(FILL_W), .IDX_W(IDX_W), .BEAT_W(BEAT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse),
        .start_ctrl(start_ctrl), .mode_q(mode_q), .addr_q(addr_q),
        .count_q(count_q), .fill(fill), .rd_data(rd_data),
        .beat_ready(beat_ready), .cons_done(cons_done),
        .beat_valid(beat_valid), .beat_data(beat_data), .rd_idx(rd_idx),
        .accept_en(accept_en), .buf_clear(buf_clear), .state_q(state_q),
        .trace_q(trace_q)
    );

    // Flatten status and trace onto plain ports.
    always_comb begin
        busy        = (state_q != ST_IDLE);
        trace_valid = trace_q.valid;
        trace_kind  = trace_q.kind;
        trace_arg0  = trace_q.a0;
        trace_arg1  = trace_q.a1;
        trace_arg2  = trace_q.a2;
        trace_arg3  = trace_q.a3;
        trace_flags = trace_q.flags;
    end

endmodule

// File: tb/dma_xfer_ctrl_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model (queue + integers) compared every clock,
// plus directed checks per requirement.
module dma_xfer_ctrl_tb;

    localparam int DEPTH = 4;
    localparam int CH    = 2;
    localparam int PATH  = 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr_en = 1'b0;
    logic [1:0]   reg_wr_sel = 2'd0;
    logic [31:0]  reg_wr_data = '0;
    logic         pl_push = 1'b0;
    logic [127:0] pl_data = '0;
    logic         beat_valid, busy, trace_valid;
    logic         beat_ready = 1'b0;
    logic         cons_done = 1'b0;
    logic [127:0] beat_data;
    logic [2:0]   trace_kind;
    logic [31:0]  trace_arg0, trace_arg1, trace_arg2, trace_arg3;
    logic [7:0]   trace_flags;

    dma_xfer_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
        .reg_wr_data(reg_wr_data), .pl_push(pl_push), .pl_data(pl_data),
        .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_data(beat_data),
        .cons_done(cons_done), .busy(busy), .trace_valid(trace_valid),
        .trace_kind(trace_kind), .trace_arg0(trace_arg0), .trace_arg1(trace_arg1),
        .trace_arg2(trace_arg2), .trace_arg3(trace_arg3), .trace_flags(trace_flags)
    );

    always #2.5 clk = ~clk;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    function automatic void check(bit ok, string tag, string what,
                                  logic [127:0] act, logic [127:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endfunction

    // ---------------- reference model ----------------
    int           m_state = 0;   // 0 idle, 1 armed, 2 active, 3 done
    logic [127:0] q[$];
    logic [31:0]  m_addr = 0;
    int           m_cnt = 0, m_mode = 0, m_planned = 0, m_sent = 0, m_code = 0;
    bit           m_tv = 0;
    int           m_tk = 0;
    logic [31:0]  m_a0, m_a1, m_a2, m_a3;
    logic [7:0]   m_fl;

    function automatic void emit(int k, logic [31:0] a0, a1, a2, a3, logic [7:0] fl);
        m_tv = 1; m_tk = k; m_a0 = a0; m_a1 = a1; m_a2 = a2; m_a3 = a3; m_fl = fl;
    endfunction

    always @(posedge clk) begin
        m_tv = 0; m_tk = 0;
        if (!rst_n) begin
            m_state = 0; q.delete(); m_addr = 0; m_cnt = 0; m_mode = 0;
        end else begin
            case (m_state)
                0: begin
                    if (pl_push && q.size() < DEPTH) q.push_back(pl_data);
                    if (reg_wr_en) begin
                        if (reg_wr_sel == 2'd1) m_addr = reg_wr_data;
                        else if (reg_wr_sel == 2'd2) m_cnt = int'(reg_wr_data[15:0]);
                        else if (reg_wr_sel == 2'd0) begin
                            m_mode = int'(reg_wr_data[3:2]);
                            if (reg_wr_data[0]) begin
                                emit(1, CH, 32'(reg_wr_data[3:0]), m_addr, m_cnt, 8'(m_mode));
                                m_state = 1;
                            end
                        end
                    end
                end
                1: begin
                    if (m_mode != 0)          begin m_planned = 0; m_code = 3; end
                    else if (m_cnt == 0)      begin m_planned = 0; m_code = 1; end
                    else if (m_cnt > q.size()) begin m_planned = q.size(); m_code = 2; end
                    else                      begin m_planned = m_cnt; m_code = 0; end
                    m_sent = 0;
                    emit(2, CH, m_cnt, m_planned, PATH, 0);
                    m_state = (m_planned == 0) ? 3 : 2;
                end
                2: begin
                    if (m_sent < m_planned && beat_ready) begin
                        emit(3, CH, m_sent, q[m_sent][31:0], m_planned - m_sent - 1, 0);
                        m_sent++;
                    end else if (m_sent == m_planned && cons_done) m_state = 3;
                end
                default: begin
                    emit(4, CH, m_sent, m_code, PATH, 0);
                    q.delete();
                    m_state = 0;
                end
            endcase
        end
    end

    // Per-clock comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit exp_bv;
            string tg;
            exp_bv = (m_state == 2 && m_sent < m_planned);
            check(beat_valid === exp_bv, "R4", "beat_valid", 128'(beat_valid), 128'(exp_bv));
            if (exp_bv) check(beat_data === q[m_sent], "R4", "beat_data", beat_data, q[m_sent]);
            check(busy === (m_state != 0), "R6", "busy", 128'(busy), 128'(m_state != 0));
            tg = (m_tk == 1) ? "R2" : (m_tk == 2) ? "R3" : (m_tk == 3) ? "R5" : "R6";
            check(trace_valid === m_tv, tg, "trace_valid", 128'(trace_valid), 128'(m_tv));
            if (m_tv) begin
                check(trace_kind === 3'(m_tk), tg, "kind", 128'(trace_kind), 128'(m_tk));
                check(trace_arg0 === m_a0, tg, "arg0", 128'(trace_arg0), 128'(m_a0));
                check(trace_arg1 === m_a1, tg, "arg1", 128'(trace_arg1), 128'(m_a1));
                check(trace_arg2 === m_a2, tg, "arg2", 128'(trace_arg2), 128'(m_a2));
                check(trace_arg3 === m_a3, tg, "arg3", 128'(trace_arg3), 128'(m_a3));
                check(trace_flags === m_fl, tg, "flags", 128'(trace_flags), 128'(m_fl));
            end
        end
    end

    // ---------------- consumer model ----------------
    int rdy_mode = 0;   // 0 always, 1 alternate, 2 held low
    bit auto_done = 1'b1;
    int cyc = 0;
    always @(negedge clk) begin
        cyc++;
        beat_ready <= (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? cyc[0] : 1'b0;
        cons_done  <= auto_done && m_state == 2 && m_sent == m_planned;
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        if (cyc > 20000 && !finished) begin
            finished = 1'b1;
            miscompares++;
            $display("FAIL watchdog: actual %0d cycles expected below 20000", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic push(input logic [127:0] d);
        @(negedge clk);
        pl_push = 1'b1; pl_data = d;
        @(negedge clk);
        pl_push = 1'b0;
    endtask

    logic [31:0] g0, g1, g2, g3;
    logic [7:0]  gf;
    task automatic grab(input int k);
        int n = 0;
        while (!(trace_valid === 1'b1 && trace_kind === 3'(k)) && n < 400) begin
            @(negedge clk);
            n++;
        end
        check(n < 400, "R6", "record arrival", 128'(n), 128'(k));
        g0 = trace_arg0; g1 = trace_arg1; g2 = trace_arg2; g3 = trace_arg3; gf = trace_flags;
    endtask

    function automatic logic [127:0] qw(input int s);
        return {32'(s) ^ 32'hA5A5_0000, 32'(s * 3), 32'hC0DE_0000 + 32'(s), 32'h1000 + 32'(s)};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        check(busy === 1'b0, "R1", "busy", 128'(busy), 0);
        check(beat_valid === 1'b0, "R1", "beat_valid", 128'(beat_valid), 0);
        check(trace_valid === 1'b0, "R1", "trace_valid", 128'(trace_valid), 0);

        // One quadword, direction bit set, delayed completion pulse.
        auto_done = 1'b0;
        push(qw(1));
        wr(2'd1, 32'h1000_0040);
        wr(2'd2, 32'd1);
        wr(2'd0, 32'h3);
        check(busy === 1'b1, "R2", "busy at cfg", 128'(busy), 1);
        grab(1);
        check(g1 === 32'h3 && g2 === 32'h1000_0040 && g3 === 32'd1, "R2", "cfg args",
              {g1, g2, g3}, {32'h3, 32'h1000_0040, 32'd1});
        grab(2);
        check(g2 === 32'd1, "R3", "planned", 128'(g2), 1);
        grab(3);
        check(g2 === qw(1)[31:0] && g3 === 0, "R5", "beat args", {g2, g3}, {qw(1)[31:0], 32'd0});
        repeat (4) @(negedge clk);
        check(busy === 1'b1, "R6", "waits for done pulse", 128'(busy), 1);
        auto_done = 1'b1;
        grab(4);
        check(g1 === 1 && g2 === 0 && g3 === PATH, "R6", "done args",
              {g1, g2, g3}, {32'd1, 32'd0, 32'(PATH)});
        check(busy === 1'b0, "R6", "busy clear with done record", 128'(busy), 0);

        // Four quadwords under an alternating stall pattern.
        rdy_mode = 1;
        for (int i = 0; i < 4; i++) push(qw(10 + i));
        wr(2'd2, 32'd4);
        wr(2'd0, 32'h1);
        grab(4);
        check(g1 === 4 && g2 === 0, "R4", "stalled stream complete", {g1, g2}, {32'd4, 32'd0});
        rdy_mode = 0;

        // Six pushes into a four-deep buffer, count 9: clamp.
        for (int i = 0; i < 6; i++) push(qw(20 + i));
        wr(2'd2, 32'd9);
        wr(2'd0, 32'h1);
        grab(2);
        check(g2 === DEPTH, "R11", "full buffer planned", 128'(g2), DEPTH);
        grab(4);
        check(g1 === DEPTH && g2 === 2, "R8", "clamp code", {g1, g2}, {32'(DEPTH), 32'd2});

        // Zero count.
        push(qw(30));
        wr(2'd2, 32'd0);
        wr(2'd0, 32'h1);
        grab(2);
        check(g2 === 0, "R7", "planned zero", 128'(g2), 0);
        grab(4);
        check(g1 === 0 && g2 === 1, "R7", "zero code", {g1, g2}, {32'd0, 32'd1});

        // Unsupported mode field.
        push(qw(40));
        wr(2'd2, 32'd1);
        wr(2'd0, 32'h5);
        grab(1);
        check(gf === 8'd1, "R9", "mode flags", 128'(gf), 1);
        grab(4);
        check(g1 === 0 && g2 === 3, "R9", "bad mode code", {g1, g2}, {32'd0, 32'd3});

        // Writes and pushes during a transfer are dropped.
        rdy_mode = 2;
        push(qw(50)); push(qw(51));
        wr(2'd1, 32'h2000_0000);
        wr(2'd2, 32'd2);
        wr(2'd0, 32'h1);
        grab(2);
        wr(2'd1, 32'hDEAD_0000);
        wr(2'd2, 32'd7);
        push(qw(52));
        rdy_mode = 0;
        grab(4);
        check(g1 === 2 && g2 === 0, "R10", "run unaffected", {g1, g2}, {32'd2, 32'd0});
        push(qw(53));
        wr(2'd0, 32'h1);
        grab(1);
        check(g2 === 32'h2000_0000 && g3 === 2, "R10", "stale regs kept",
              {g2, g3}, {32'h2000_0000, 32'd2});
        grab(3);
        check(g2 === qw(53)[31:0], "R10", "busy-time push dropped", 128'(g2), 128'(qw(53)[31:0]));
        grab(4);
        check(g2 === 2, "R8", "clamp to one loaded", 128'(g2), 2);

        // Buffer empties on completion: no pushes, count 2.
        wr(2'd0, 32'h1);
        grab(2);
        check(g2 === 0, "R11", "buffer emptied", 128'(g2), 0);
        grab(4);
        check(g1 === 0 && g2 === 2, "R8", "nothing loaded", {g1, g2}, {32'd0, 32'd2});

        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule